// File: doc/BRIEF.md
# Dual-Edge FIFO Write Front End

This block sits between a write-side data bus and the storage of a FIFO. A static configuration input picks the rate. In single-rate mode one word is taken on each rising edge of the write clock. In double-rate mode a second word is also taken on the falling edge of the same clock period. The enable decision is made only at the rising edge. In double-rate mode that one decision admits both the rising-edge word and the word that follows it on the falling edge.

The falling-edge word is held in a negative-edge register. It is then handed to the storage on the next rising edge, together with the rising-edge word, as a second write lane. Lane 0 always carries the older word and lane 1 the newer one, so the storage side sees an ordered stream and uses only one clock edge. The FIFO reports its fill state on two inputs: completely full, and exactly one free slot. Full blocks every word. When a double-rate pair arrives and only one slot is free, the rising-edge word is kept, the falling-edge word is discarded, and a one-cycle overflow pulse is raised.

All outputs are registered. A rising-edge decision at clock edge t appears on the outputs after edge t+1. When the clock stops, nothing is written and the outputs keep their values.

Top module: `ddr_wr_port`

## Requirements
- R1: While `rst` is high at a rising edge, all strobes and the overflow pulse are low after that edge.
- R2: With `ddr_mode` = 0, a word that is qualified at rising edge t appears on `mem_wd0` with `mem_we0` high during the cycle after edge t+1. `mem_we1` is never high in this mode.
- R3: With `ddr_mode` = 1, a qualified and admitted pair is presented in the same cycle: the rising-edge word on lane 0 and the word present at the following falling edge on lane 1. Lane 1 is never strobed without lane 0.
- R4: A word is qualified only when both `wen_n` and `wcs_n` are low at the rising edge. The enable levels between a rising edge and the next rising edge have no effect, including at the falling edge.
- R5: While `fifo_full` is high at the rising edge, no word is written in either mode. A qualified request that cycle raises `wr_ovf` for one cycle, aligned with where its strobes would have appeared.
- R6: In double-rate mode, with `fifo_one_left` high and `fifo_full` low, a qualified cycle writes only the rising-edge word and raises `wr_ovf`. `fifo_full` takes precedence over `fifo_one_left`.
- R7: `wr_ovf` is high only for a qualified request that lost at least one word. `wr_ovf` and `mem_we1` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock; both edges are used in double-rate mode |
| rst | input | 1 | Synchronous active-high reset |
| ddr_mode | input | 1 | Static rate select: 1 = both edges, 0 = rising edge only |
| wen_n | input | 1 | Write enable, active low, sampled at the rising edge |
| wcs_n | input | 1 | Write chip select, active low, sampled at the rising edge |
| wdata | input | DATA_W | Write data, sampled on the active edges |
| fifo_full | input | 1 | FIFO has no free slot |
| fifo_one_left | input | 1 | FIFO has exactly one free slot |
| mem_we0 | output | 1 | Strobe for the older word (rising-edge sample) |
| mem_wd0 | output | DATA_W | Older word |
| mem_we1 | output | 1 | Strobe for the newer word (falling-edge sample) |
| mem_wd1 | output | DATA_W | Newer word |
| wr_ovf | output | 1 | One-cycle pulse when a qualified word was discarded |

## Verification
Two things can happen in the same rising-edge decision: a double-rate pair is admitted, and the capacity check cuts that pair short because only one slot is free. The bench provokes this by raising `fifo_one_left` during qualified double-rate cycles, and by raising it together with `fifo_full`. It then judges whether lane 0 keeps the older word, lane 1 stays silent, and `wr_ovf` pulses in that same output cycle. A behavioural model built on queues predicts the strobes and words for every clock. The complete written stream is also compared against the queue of admitted words, so a dropped or swapped word is caught even when each cycle looks plausible on its own.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;

    typedef enum logic {
        RATE_SINGLE = 1'b0,
        RATE_DOUBLE = 1'b1
    } rate_e;

    // Outcome of one rising-edge admission decision
    typedef struct packed {
        logic take_rise;   // rising-edge word goes to lane 0
        logic take_fall;   // following falling-edge word goes to lane 1
        logic lost;        // a qualified word was discarded
    } admit_t;

    localparam admit_t ADMIT_NONE = '{take_rise: 1'b0, take_fall: 1'b0, lost: 1'b0};

    function automatic admit_t decide(
        input logic  qual,
        input rate_e rate,
        input logic  full,
        input logic  one_left
    );
        admit_t r;
        r.take_rise = qual && !full;
        r.take_fall = qual && !full && (rate == RATE_DOUBLE) && !one_left;
        r.lost      = qual && (full || ((rate == RATE_DOUBLE) && one_left));
        return r;
    endfunction

endpackage

// File: rtl/ddr_wr_qualify.sv
module ddr_wr_qualify
    import ddr_wr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  rate_e             rate,
    input  logic              wen_n,
    input  logic              wcs_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fifo_full,
    input  logic              fifo_one_left,
    output admit_t            admit_q,
    output logic [DATA_W-1:0] rise_word_q
);

    logic qual;
    assign qual = !wen_n && !wcs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            admit_q     <= ADMIT_NONE;
            rise_word_q <= '0;
        end else begin
            admit_q     <= decide(qual, rate, fifo_full, fifo_one_left);
            rise_word_q <= wdata;
        end
    end

    // R6: a cut-short pair still keeps its older word
    a_r6_keep_rise: assert property (@(posedge clk) disable iff (rst)
        (qual && !fifo_full && (rate == RATE_DOUBLE) && fifo_one_left)
            |=> (admit_q.take_rise && !admit_q.take_fall && admit_q.lost));

endmodule

// File: rtl/ddr_wr_fall_capture.sv
module ddr_wr_fall_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              arm,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] fall_word_q
);

    // Loaded only when the preceding rising edge admitted a pair
    always_ff @(negedge clk) begin
        if (arm) begin
            fall_word_q <= wdata;
        end
    end

endmodule

// File: rtl/ddr_wr_merge.sv
module ddr_wr_merge
    import ddr_wr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  admit_t            admit_q,
    input  logic [DATA_W-1:0] rise_word_q,
    input  logic [DATA_W-1:0] fall_word_q,
    output logic [LANES-1:0]  lane_we,
    output logic [DATA_W-1:0] lane_wd [LANES],
    output logic              ovf
);

    logic [LANES-1:0]  src_we;
    logic [DATA_W-1:0] src_wd [LANES];

    assign src_we[0] = admit_q.take_rise;
    assign src_we[1] = admit_q.take_fall;
    assign src_wd[0] = rise_word_q;
    assign src_wd[1] = fall_word_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_we[g] <= 1'b0;
                lane_wd[g] <= '0;
            end else begin
                lane_we[g] <= src_we[g];
                lane_wd[g] <= src_wd[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ovf <= 1'b0;
        else     ovf <= admit_q.lost;
    end

    // R3: newer lane never strobed alone
    a_r3_lane_order: assert property (@(posedge clk) disable iff (rst)
        lane_we[1] |-> lane_we[0]);

endmodule

// File: rtl/ddr_wr_port.sv
module ddr_wr_port
    import ddr_wr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ddr_mode,
    input  logic              wen_n,
    input  logic              wcs_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fifo_full,
    input  logic              fifo_one_left,
    output logic              mem_we0,
    output logic [DATA_W-1:0] mem_wd0,
    output logic              mem_we1,
    output logic [DATA_W-1:0] mem_wd1,
    output logic              wr_ovf
);

    localparam int LANES = 2;

    rate_e             rate;
    admit_t            admit_q;
    logic [DATA_W-1:0] rise_word_q;
    logic [DATA_W-1:0] fall_word_q;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] lane_wd [LANES];

    assign rate = ddr_mode ? RATE_DOUBLE : RATE_SINGLE;

    ddr_wr_qualify #(.DATA_W(DATA_W)) u_qual (
        .clk          (clk),
        .rst          (rst),
        .rate         (rate),
        .wen_n        (wen_n),
        .wcs_n        (wcs_n),
        .wdata        (wdata),
        .fifo_full    (fifo_full),
        .fifo_one_left(fifo_one_left),
        .admit_q      (admit_q),
        .rise_word_q  (rise_word_q)
    );

    ddr_wr_fall_capture #(.DATA_W(DATA_W)) u_fall (
        .clk        (clk),
        .arm        (admit_q.take_fall),
        .wdata      (wdata),
        .fall_word_q(fall_word_q)
    );

    ddr_wr_merge #(.DATA_W(DATA_W), .LANES(LANES)) u_merge (
        .clk        (clk),
        .rst        (rst),
        .admit_q    (admit_q),
        .rise_word_q(rise_word_q),
        .fall_word_q(fall_word_q),
        .lane_we    (lane_we),
        .lane_wd    (lane_wd),
        .ovf        (wr_ovf)
    );

    assign mem_we0 = lane_we[0];
    assign mem_we1 = lane_we[1];
    assign mem_wd0 = lane_wd[0];
    assign mem_wd1 = lane_wd[1];

    // R1: reset leaves the outputs quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!mem_we0 && !mem_we1 && !wr_ovf));

    // R2: single-rate mode never uses the second lane
    a_r2_single_lane: assert property (@(posedge clk) disable iff (rst)
        (!ddr_mode && $past(!ddr_mode)) |-> !mem_we1);

    // R5: full at the deciding edge blocks both lanes two edges later
    a_r5_full_blocks: assert property (@(posedge clk) disable iff (rst)
        fifo_full |=> ##1 (!mem_we0 && !mem_we1));

    // R7: a loss pulse never coincides with a second-lane write
    a_r7_ovf_excl: assert property (@(posedge clk) disable iff (rst)
        !(wr_ovf && mem_we1));

endmodule

// File: tb/ddr_wr_port_test.sv
module ddr_wr_port_test;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ddr_mode = 1'b0;
    logic         wen_n = 1'b1;
    logic         wcs_n = 1'b1;
    logic [W-1:0] wdata = '0;
    logic         fifo_full = 1'b0;
    logic         fifo_one_left = 1'b0;
    logic         mem_we0, mem_we1, wr_ovf;
    logic [W-1:0] mem_wd0, mem_wd1;

    int checks = 0;
    int errors = 0;

    bit           p_we0, p_we1, p_ovf;
    logic [W-1:0] p_d0, p_d1;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] got_q[$];

    ddr_wr_port #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst), .ddr_mode(ddr_mode), .wen_n(wen_n), .wcs_n(wcs_n),
        .wdata(wdata), .fifo_full(fifo_full), .fifo_one_left(fifo_one_left),
        .mem_we0(mem_we0), .mem_wd0(mem_wd0), .mem_we1(mem_we1), .mem_wd1(mem_wd1),
        .wr_ovf(wr_ovf)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One write-clock period: rising-edge controls/data, then falling-edge data
    task automatic step(bit en, bit cs, bit full, bit one,
                        logic [W-1:0] rw, logic [W-1:0] fw, bit flip);
        bit qual, acc, pair, lost;
        wen_n = !en; wcs_n = !cs; fifo_full = full; fifo_one_left = one; wdata = rw;
        @(posedge clk);
        #1;
        // outputs now reflect the previous decision
        chk(ddr_mode ? "R3 lane0 strobe" : "R2 lane0 strobe", mem_we0, p_we0);
        if (p_we0) chk(ddr_mode ? "R3 lane0 word" : "R2 lane0 word", mem_wd0, p_d0);
        chk(ddr_mode ? "R3 lane1 strobe" : "R2 lane1 idle", mem_we1, p_we1);
        if (p_we1) chk("R3 lane1 word", mem_wd1, p_d1);
        chk("R5 R6 R7 overflow", wr_ovf, p_ovf);
        if (mem_we0) got_q.push_back(mem_wd0);
        if (mem_we1) got_q.push_back(mem_wd1);
        // model for the decision just made
        qual = en && cs;
        acc  = qual && !full;
        pair = acc && ddr_mode && !one;
        lost = qual && (full || (ddr_mode && one));
        p_we0 = acc; p_we1 = pair; p_ovf = lost; p_d0 = rw; p_d1 = fw;
        if (acc)  exp_q.push_back(rw);
        if (pair) exp_q.push_back(fw);
        #1;
        wdata = fw;
        if (flip) begin   // R4: enables toggled after the rising edge
            wen_n = en; wcs_n = cs;
        end
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset(bit mode);
        rst = 1'b1; ddr_mode = mode; wen_n = 1'b0; wcs_n = 1'b0; fifo_full = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset lane0", mem_we0, 1'b0);
        chk("R1 reset lane1", mem_we1, 1'b0);
        chk("R1 reset ovf",   wr_ovf,  1'b0);
        p_we0 = 0; p_we1 = 0; p_ovf = 0;
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        p_we0 = 0; p_we1 = 0; p_ovf = 0; p_d0 = '0; p_d1 = '0;

        // ---- single-rate mode: R2, R4, R5
        do_reset(1'b0);
        for (int i = 0; i < 8; i++) step(1, 1, 0, 0, W'(12'h100 + i), W'(12'hE00 + i), 0);
        step(0, 1, 0, 0, 12'h1A1, 12'hEA1, 0);       // R4 enable high
        step(1, 0, 0, 0, 12'h1A2, 12'hEA2, 0);       // R4 select high
        step(1, 1, 0, 1, 12'h1A3, 12'hEA3, 0);       // one slot is enough in single rate
        step(1, 1, 1, 0, 12'h1A4, 12'hEA4, 0);       // R5 full blocks
        step(0, 0, 0, 0, 12'h1A5, 12'hEA5, 1);       // R4 late enable ignored
        for (int i = 0; i < 10; i++) step(i % 3 != 0, 1, i == 7, 0, W'(12'h200 + i), W'(12'hF00 + i), 0);
        step(0, 1, 0, 0, 12'h000, 12'h000, 0);

        // ---- double-rate mode: R3, R4, R5, R6, R7
        do_reset(1'b1);
        for (int i = 0; i < 8; i++) step(1, 1, 0, 0, W'(12'h300 + 2*i), W'(12'h301 + 2*i), 0);
        step(1, 1, 0, 0, 12'h3B0, 12'h3B1, 1);       // R4 enable dropped before falling edge
        step(0, 1, 0, 0, 12'h3B2, 12'h3B3, 1);       // R4 enable raised after rising edge
        step(1, 1, 0, 1, 12'h3C0, 12'h3C1, 0);       // R6 one slot: keep rising word
        step(1, 1, 1, 1, 12'h3C2, 12'h3C3, 0);       // R6 full wins
        step(1, 1, 1, 0, 12'h3C4, 12'h3C5, 0);       // R5 full blocks pair
        step(0, 1, 1, 0, 12'h3C6, 12'h3C7, 0);       // R7 no request, no pulse
        for (int i = 0; i < 16; i++)
            step(i % 4 != 1, i % 5 != 2, i == 9, i % 6 == 3, W'(12'h400 + 2*i), W'(12'h401 + 2*i), i % 7 == 4);
        step(0, 1, 0, 0, 12'h000, 12'h000, 0);
        step(0, 1, 0, 0, 12'h000, 12'h000, 0);

        // R3: written stream equals admitted words in order
        chk("R3 stream length", W'(got_q.size()), W'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk("R3 stream order", got_q[i], exp_q[i]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule